// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block is the write-side controller of a byte-wide parallel EEPROM region. A host drives chip enable, write enable, output enable, address and data as level signals, and the block samples them in its own clock domain. Bytes that belong to one 64-byte page are gathered in a page buffer. While the host keeps strobing bytes inside a load window, the page stays open. Once the host goes quiet for a full window, the block runs a timed internal write and then moves the buffered bytes into the storage array, which is modelled as registers.

The active-high `ready` output falls when the first byte of a load is accepted. It rises again when the write cycle ends, or when a load ends without anything to write. A read made while the block is busy returns status instead of array data: bit 7 is the inverse of bit 7 of the last accepted byte, and bit 6 flips after each read. A software protection flag is kept across reset. Once the flag is set, a load must start with a three-byte key, and any load without that key is dropped.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: While reset is held, and in idle with no read strobe, `ready` is 1 and `dout_en` is 0. `dout_en` is 1 while `ce_n`=0, `oe_n`=0 and `we_n`=1.
- R2: For POWERUP_CYC cycles after reset is released, every write strobe is ignored and `ready` stays 1.
- R3: A write strobe is active when `ce_n`=0, `we_n`=0 and `oe_n`=1. The address is the value present in the first active cycle. The data is the value present in the last active cycle.
- R4: Bytes whose strobes are spaced less than the load window apart all land in one page write, and each can be read back after `ready` returns to 1.
- R5: The first data byte of a load fixes the page (address bits [14:6]). Later data bytes of the same load that carry another page are dropped.
- R6: `ready` falls one cycle after the first accepted strobe ends. The internal write starts when LOAD_MAX_CYC cycles pass after the last strobe of the load, or LOAD_MIN_CYC cycles if that is larger. The write lasts WRITE_CYC cycles, so `ready` rises LOAD_MAX_CYC+WRITE_CYC cycles after the last strobe ends.
- R7: A read while `ready`=0 returns bit 7 equal to the inverse of bit 7 of the last accepted byte. Bit 6 changes between successive reads. After `ready` rises, reads return array data.
- R8: Write strobes made during the internal write cycle change neither the array nor the busy timing.
- R9: The key AAh@5555h, 55h@2AAAh, A0h@5555h at the start of a load sets protection at the end of that load's write cycle. Data bytes that follow the key in the same load are written, whether or not protection was already set.
- R10: While protection is set, a load that does not begin with the key is discarded: nothing is stored and `ready` stays 1.
- R11: The six-byte sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h runs one full write cycle and then clears protection.
- R12: The protection flag and the array contents are unchanged by `rst_n`.
- R13: The page buffer is emptied when a new load begins, so a load stores only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and timing clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | 15 | Byte address; bits [14:6] select the page |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or busy status |
| dout_en | output | 1 | High while a read strobe is active |
| ready | output | 1 | 1 = ready, 0 = loading or internal write busy |

## Verification
A write strobe is taken on the first clock edge at which the bus shows it inactive. From that edge, `ready` is due low one edge later. It is due high exactly LOAD_MAX_CYC+WRITE_CYC edges after that edge, and the array holds the new data on the same edge. The bench's bus tasks return half a cycle after the capturing edge. The timing test then counts that exact number of falling clock edges and checks `ready` one cycle before and one cycle after it is due. Read data and status bits come from combinational logic driven by the bus, so reads are sampled 1 ns after the bus is driven. The status bit 6 flips on the edge after each read ends, so the second of two reads in one busy period must show the opposite value. Checks that a write is ignored wait at least one full load window, then look at `ready` and read the target byte back.

// File: rtl/epw_pkg.sv
package epw_pkg;
    localparam int ADDR_W = 15;
    localparam int OFS_W  = 6;
    localparam int PAGE_W = ADDR_W - OFS_W;

    localparam logic [ADDR_W-1:0] KEY_ADR_HI = 15'h5555;
    localparam logic [ADDR_W-1:0] KEY_ADR_LO = 15'h2AAA;
    localparam logic [7:0] KEY_B0    = 8'hAA;
    localparam logic [7:0] KEY_B1    = 8'h55;
    localparam logic [7:0] CMD_LOCK  = 8'hA0;
    localparam logic [7:0] CMD_OPEN1 = 8'h80;
    localparam logic [7:0] CMD_OPEN2 = 8'h20;

    typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_WRITE} phase_e;

    typedef enum logic [3:0] {
        KS_START, KS_AA, KS_55, KS_LOCKED, KS_80, KS_AA2, KS_552,
        KS_DATA, KS_UNLOCK, KS_BAD
    } key_e;
endpackage

// File: rtl/epw_bus_capture.sv
module epw_bus_capture
    import epw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              byte_vld,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [7:0]        byte_data,
    output logic              rd_act,
    output logic              rd_end
);
    typedef struct packed {
        logic              wact;
        logic              ract;
        logic [ADDR_W-1:0] adr;
        logic [7:0]        dat;
    } cap_t;

    cap_t cap_d, cap_q;
    logic wr_act;

    always_comb begin
        wr_act    = !ce_n && !we_n && oe_n;
        rd_act    = !ce_n && !oe_n && we_n;
        cap_d      = cap_q;
        cap_d.wact = wr_act;
        cap_d.ract = rd_act;
        if (wr_act && !cap_q.wact) cap_d.adr = addr;   // later falling edge
        if (wr_act)                cap_d.dat = din;    // held until earlier rising edge
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign byte_vld  = cap_q.wact && !wr_act;
    assign byte_addr = cap_q.adr;
    assign byte_data = cap_q.dat;
    assign rd_end    = cap_q.ract && !rd_act;
endmodule

// File: rtl/epw_key_dec.sv
module epw_key_dec
    import epw_pkg::*;
(
    input  key_e              cur,
    input  logic              prot,
    input  logic [ADDR_W-1:0] adr,
    input  logic [7:0]        dat,
    output key_e              nxt,
    output logic              consume,
    output logic              store
);
    logic at_hi, is_b0, is_b1, miss;

    always_comb begin
        at_hi   = (adr == KEY_ADR_HI);
        is_b0   = at_hi && (dat == KEY_B0);
        is_b1   = (adr == KEY_ADR_LO) && (dat == KEY_B1);
        nxt     = cur;
        consume = 1'b0;
        store   = 1'b0;
        miss    = 1'b0;
        unique case (cur)
            KS_START: if (is_b0) begin nxt = KS_AA; consume = 1'b1; end else miss = 1'b1;
            KS_AA:    if (is_b1) begin nxt = KS_55; consume = 1'b1; end else miss = 1'b1;
            KS_55: begin
                if (at_hi && dat == CMD_LOCK) begin
                    nxt = KS_LOCKED; consume = 1'b1;
                end else if (at_hi && dat == CMD_OPEN1) begin
                    nxt = KS_80; consume = 1'b1;
                end else miss = 1'b1;
            end
            KS_80:    if (is_b0) begin nxt = KS_AA2; consume = 1'b1; end else miss = 1'b1;
            KS_AA2:   if (is_b1) begin nxt = KS_552; consume = 1'b1; end else miss = 1'b1;
            KS_552: begin
                if (at_hi && dat == CMD_OPEN2) begin
                    nxt = KS_UNLOCK; consume = 1'b1;
                end else miss = 1'b1;
            end
            KS_LOCKED, KS_DATA: store = 1'b1;
            default: ;   // KS_UNLOCK, KS_BAD: rest of load ignored
        endcase
        if (miss) begin
            if (prot) nxt = KS_BAD;
            else begin
                nxt   = KS_DATA;
                store = 1'b1;
            end
        end
    end
endmodule

// File: rtl/epw_page_store.sv
module epw_page_store #(
    parameter int OFS_W    = 6,
    parameter int MEM_PG_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      wr_en,
    input  logic [OFS_W-1:0]          wr_ofs,
    input  logic [7:0]                wr_data,
    input  logic                      commit,
    input  logic [MEM_PG_W-1:0]       commit_pg,
    input  logic [MEM_PG_W+OFS_W-1:0] rd_addr,
    output logic [7:0]                rd_data
);
    localparam int BYTES = 1 << OFS_W;
    localparam int DEPTH = 1 << (MEM_PG_W + OFS_W);

    logic [7:0]       buf_q [BYTES];
    logic [BYTES-1:0] vld_d, vld_q;
    logic [7:0]       mem_q [DEPTH];

    always_comb begin
        vld_d = clr ? '0 : vld_q;
        if (wr_en) vld_d[wr_ofs] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) buf_q[wr_ofs] <= wr_data;
    end

    // array is non-volatile: no reset
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < BYTES; i++) begin
                if (vld_q[i]) mem_q[{commit_pg, OFS_W'(i)}] <= buf_q[i];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
    import epw_pkg::*;
#(
    parameter int MEM_PG_W     = 4,
    parameter int LOAD_MIN_CYC = 40,
    parameter int LOAD_MAX_CYC = 30000,
    parameter int WRITE_CYC    = 2000000,
    parameter int POWERUP_CYC  = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              ready
);
    localparam int LOAD_TO = (LOAD_MAX_CYC > LOAD_MIN_CYC) ? LOAD_MAX_CYC : LOAD_MIN_CYC;
    localparam int LCNT_W  = $clog2(LOAD_TO + 1);
    localparam int WCNT_W  = $clog2(WRITE_CYC + 1);
    localparam int PCNT_W  = $clog2(POWERUP_CYC + 1);
    localparam int RADR_W  = MEM_PG_W + OFS_W;

    typedef struct packed {
        phase_e              ph;
        key_e                key;
        logic                has_data;
        logic [PAGE_W-1:0]   page;
        logic [LCNT_W-1:0]   gap;
        logic [WCNT_W-1:0]   wcnt;
        logic [PCNT_W-1:0]   pcnt;
        logic                pu_done;
        logic                tgl;
        logic                last_b7;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic prot_d, prot_q;

    logic              byte_vld, rd_act, rd_end;
    logic [ADDR_W-1:0] b_addr;
    logic [7:0]        b_data, mem_rd;
    logic [PAGE_W-1:0] b_page;
    key_e              kd_next;
    logic              kd_consume, kd_store;
    logic              absorb, buf_clr, buf_wr, commit;
    logic              in_write, pu_done_w, tgl_w;

    epw_bus_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .din       (din),
        .byte_vld  (byte_vld),
        .byte_addr (b_addr),
        .byte_data (b_data),
        .rd_act    (rd_act),
        .rd_end    (rd_end)
    );

    epw_key_dec u_key (
        .cur     (ctl_q.key),
        .prot    (prot_q),
        .adr     (b_addr),
        .dat     (b_data),
        .nxt     (kd_next),
        .consume (kd_consume),
        .store   (kd_store)
    );

    epw_page_store #(.OFS_W(OFS_W), .MEM_PG_W(MEM_PG_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .wr_en     (buf_wr),
        .wr_ofs    (b_addr[OFS_W-1:0]),
        .wr_data   (b_data),
        .commit    (commit),
        .commit_pg (ctl_q.page[MEM_PG_W-1:0]),
        .rd_addr   (addr[RADR_W-1:0]),
        .rd_data   (mem_rd)
    );

    assign b_page = b_addr[ADDR_W-1:OFS_W];

    always_comb begin
        ctl_d   = ctl_q;
        prot_d  = prot_q;
        absorb  = 1'b0;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        commit  = 1'b0;

        // power-up write inhibit
        if (!ctl_q.pu_done) begin
            if (ctl_q.pcnt == PCNT_W'(POWERUP_CYC - 1)) ctl_d.pu_done = 1'b1;
            else                                        ctl_d.pcnt    = ctl_q.pcnt + 1'b1;
        end

        // byte arrival
        if (byte_vld && ctl_q.pu_done) begin
            if (ctl_q.ph == PH_IDLE && (kd_consume || kd_store)) begin
                ctl_d.ph       = PH_LOAD;
                ctl_d.has_data = 1'b0;
                ctl_d.gap      = '0;
                buf_clr        = 1'b1;
                absorb         = 1'b1;
            end else if (ctl_q.ph == PH_LOAD) begin
                ctl_d.gap = '0;
                absorb    = 1'b1;
            end
        end

        if (absorb && !(kd_store && ctl_d.has_data && b_page != ctl_d.page)) begin
            ctl_d.key = kd_next;
            if (kd_consume || kd_store) ctl_d.last_b7 = b_data[7];
            if (kd_store) begin
                buf_wr = 1'b1;
                if (!ctl_d.has_data) ctl_d.page = b_page;
                ctl_d.has_data = 1'b1;
            end
        end

        // load window expiry
        if (ctl_q.ph == PH_LOAD && !byte_vld) begin
            if (ctl_q.gap == LCNT_W'(LOAD_TO - 1)) begin
                if (ctl_q.key == KS_LOCKED || ctl_q.key == KS_UNLOCK ||
                    (ctl_q.key == KS_DATA && ctl_q.has_data)) begin
                    ctl_d.ph   = PH_WRITE;
                    ctl_d.wcnt = '0;
                end else begin
                    ctl_d.ph  = PH_IDLE;
                    ctl_d.key = KS_START;
                end
            end else begin
                ctl_d.gap = ctl_q.gap + 1'b1;
            end
        end

        // timed internal write
        if (ctl_q.ph == PH_WRITE) begin
            if (ctl_q.wcnt == WCNT_W'(WRITE_CYC - 1)) begin
                ctl_d.ph  = PH_IDLE;
                ctl_d.key = KS_START;
                commit    = ctl_q.has_data;
                if (ctl_q.key == KS_LOCKED)      prot_d = 1'b1;
                else if (ctl_q.key == KS_UNLOCK) prot_d = 1'b0;
            end else begin
                ctl_d.wcnt = ctl_q.wcnt + 1'b1;
            end
        end

        if (rd_end && ctl_q.ph != PH_IDLE) ctl_d.tgl = !ctl_q.tgl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_d_reset: begin
                ctl_q     <= '0;
                ctl_q.ph  <= PH_IDLE;
                ctl_q.key <= KS_START;
            end
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // protection flag is non-volatile: no reset
    always_ff @(posedge clk) begin
        prot_q <= prot_d;
    end

    assign ready     = (ctl_q.ph == PH_IDLE);
    assign dout_en   = rd_act;
    assign dout      = ready ? mem_rd : {!ctl_q.last_b7, ctl_q.tgl, 6'b0};
    assign in_write  = (ctl_q.ph == PH_WRITE);
    assign pu_done_w = ctl_q.pu_done;
    assign tgl_w     = ctl_q.tgl;
endmodule

// File: rtl/epw_chk.sv
module epw_chk
    import epw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              byte_vld,
    input logic [ADDR_W-1:0] b_addr,
    input logic [7:0]        b_data,
    input logic              in_write,
    input logic              prot,
    input logic              pu_done,
    input logic              rd_end,
    input logic              tgl
);
    // R2
    pu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pu_done |=> ready);

    // R10
    nokey_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && prot && byte_vld && !(b_addr == KEY_ADR_HI && b_data == KEY_B0)) |=> ready);

    // R12
    prot_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot) |-> $past(in_write));

    // R6
    write_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_write) |-> $past(!ready));

    // R6
    busy_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(byte_vld));

    // R7
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && !ready) |=> (tgl != $past(tgl)));
endmodule

bind eeprom_page_ctrl epw_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .byte_vld (byte_vld),
    .b_addr   (b_addr),
    .b_data   (b_data),
    .in_write (in_write),
    .prot     (prot_q),
    .pu_done  (pu_done_w),
    .rd_end   (rd_end),
    .tgl      (tgl_w)
);

// File: tb/test_eeprom_page_ctrl.sv
`timescale 1ns/1ps
module test_eeprom_page_ctrl;
    localparam int LMIN = 2;
    localparam int LMAX = 20;
    localparam int WCYC = 60;
    localparam int PCYC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en, ready;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    eeprom_page_ctrl #(
        .MEM_PG_W(4), .LOAD_MIN_CYC(LMIN), .LOAD_MAX_CYC(LMAX),
        .WRITE_CYC(WCYC), .POWERUP_CYC(PCYC)
    ) i_eeprom_page_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .ready(ready)
    );

    // {address, data}
    localparam logic [22:0] VEC [6] = '{
        {15'h0012, 8'h3C}, {15'h0104, 8'h11}, {15'h0205, 8'h22},
        {15'h01C5, 8'h55}, {15'h0241, 8'h66}, {15'h03FF, 8'hA5}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write_split(input logic [14:0] a1, input logic [14:0] a2,
                                   input logic [7:0] d1, input logic [7:0] d2);
        @(negedge clk); addr = a1; din = d1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); addr = a2; din = d2;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [14:0] a, output logic [7:0] d, output logic en);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #1 d = dout; en = dout_en;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && ready !== 1'b1; i++) @(negedge clk);
    endtask

    task automatic unlock_seq();
        bus_write(15'h5555, 8'hAA); bus_write(15'h2AAA, 8'h55); bus_write(15'h5555, 8'h80);
        bus_write(15'h5555, 8'hAA); bus_write(15'h2AAA, 8'h55); bus_write(15'h5555, 8'h20);
    endtask

    task automatic lock_key();
        bus_write(15'h5555, 8'hAA); bus_write(15'h2AAA, 8'h55); bus_write(15'h5555, 8'hA0);
    endtask

    task automatic read_chk(input string tag, input logic [14:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic       en;
        bus_read(a, d, en);
        chk(tag, {24'h0, d}, {24'h0, exp});
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       en;
        logic       t1;
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", {31'h0, ready}, 32'h1);
        chk("R1 dout_en in reset", {31'h0, dout_en}, 32'h0);
        rst_n = 1'b1;

        // R2: write during power-up inhibit
        bus_write(15'h0100, 8'h5A);
        chk("R2 ready after early write", {31'h0, ready}, 32'h1);
        repeat (LMAX + 2) @(negedge clk);
        chk("R2 no load after early write", {31'h0, ready}, 32'h1);
        repeat (PCYC) @(negedge clk);

        // bring protection to a known cleared state
        unlock_seq();
        wait_idle();

        // R4 / R6: table of single-byte page writes
        for (int i = 0; i < 6; i++) begin
            bus_write(VEC[i][22:8], VEC[i][7:0]);
            chk("R6 busy after byte", {31'h0, ready}, 32'h0);
            wait_idle();
            bus_read(VEC[i][22:8], d, en);
            chk("R4 readback", {24'h0, d}, {24'h0, VEC[i][7:0]});
            chk("R1 dout_en during read", {31'h0, en}, 32'h1);
        end
        chk("R1 dout_en idle", {31'h0, dout_en}, 32'h0);

        // R6: exact completion cycle
        bus_write(15'h0040, 8'h81);
        repeat (LMAX + WCYC - 1) @(negedge clk);
        chk("R6 still busy one cycle before end", {31'h0, ready}, 32'h0);
        @(negedge clk);
        chk("R6 ready at end", {31'h0, ready}, 32'h1);
        read_chk("R6 data after cycle", 15'h0040, 8'h81);

        // R7: status reads while busy
        bus_write(15'h0050, 8'hC3);
        bus_read(15'h0050, d, en);
        chk("R7 dq7 first read", {31'h0, d[7]}, 32'h0);
        t1 = d[6];
        bus_read(15'h0050, d, en);
        chk("R7 dq7 second read", {31'h0, d[7]}, 32'h0);
        chk("R7 dq6 toggles", {31'h0, d[6]}, {31'h0, ~t1});
        wait_idle();
        read_chk("R7 true data after", 15'h0050, 8'hC3);

        // R4: multi-byte page load
        for (int i = 0; i < 4; i++) bus_write(15'h0080 + 15'(i), 8'h10 + 8'(i * 17));
        wait_idle();
        for (int i = 0; i < 4; i++) read_chk("R4 page byte", 15'h0080 + 15'(i), 8'h10 + 8'(i * 17));

        // R5: off-page byte dropped
        bus_write(15'h00C0, 8'h66);
        bus_write(15'h0104, 8'h77);
        wait_idle();
        read_chk("R5 first page byte", 15'h00C0, 8'h66);
        read_chk("R5 off-page untouched", 15'h0104, 8'h11);

        // R8: write during internal cycle
        bus_write(15'h0200, 8'h99);
        repeat (LMAX + 2) @(negedge clk);
        bus_write(15'h0205, 8'hEE);
        wait_idle();
        repeat (LMAX + 5) @(negedge clk);
        chk("R8 no extra cycle", {31'h0, ready}, 32'h1);
        read_chk("R8 target unchanged", 15'h0205, 8'h22);

        // R13: buffer emptied between loads
        bus_write(15'h0185, 8'h33);
        wait_idle();
        bus_write(15'h01C6, 8'h44);
        wait_idle();
        read_chk("R13 stale offset untouched", 15'h01C5, 8'h55);
        read_chk("R13 new byte", 15'h01C6, 8'h44);

        // R3: address at start, data at end of strobe
        bus_write_split(15'h0240, 15'h0241, 8'h01, 8'h02);
        wait_idle();
        read_chk("R3 address from first cycle", 15'h0240, 8'h02);
        read_chk("R3 later address untouched", 15'h0241, 8'h66);

        // R9: set protection with data
        lock_key();
        bus_write(15'h0300, 8'h7E);
        wait_idle();
        read_chk("R9 data after key", 15'h0300, 8'h7E);

        // R10: keyless write discarded
        bus_write(15'h0012, 8'h00);
        chk("R10 no busy", {31'h0, ready}, 32'h1);
        repeat (LMAX + 3) @(negedge clk);
        chk("R10 still ready", {31'h0, ready}, 32'h1);
        read_chk("R10 data kept", 15'h0012, 8'h3C);

        // R9: protected write with key
        lock_key();
        bus_write(15'h0012, 8'hC8);
        wait_idle();
        read_chk("R9 keyed write while protected", 15'h0012, 8'hC8);

        // R12: protection survives reset
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        repeat (PCYC + 2) @(negedge clk);
        bus_write(15'h0012, 8'h01);
        repeat (LMAX + 3) @(negedge clk);
        chk("R12 still protected", {31'h0, ready}, 32'h1);
        read_chk("R12 array kept", 15'h0012, 8'hC8);

        // R11: clear protection
        unlock_seq();
        chk("R11 busy after unlock", {31'h0, ready}, 32'h0);
        wait_idle();
        bus_write(15'h0012, 8'h02);
        wait_idle();
        read_chk("R11 plain write works", 15'h0012, 8'h02);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule